// File: doc/BRIEF.md
# Joint Translation Buffer with Command Register Port

The block is a set-associative joint translation buffer that software manages through four registers: an index register, two page-descriptor registers and a command register. The first descriptor holds the match key, which is the virtual page number, the address-space identifier and a present bit. The second descriptor holds the frame number and the permission bits. A command is started by writing its code to the command register. It runs in the next cycle, and the busy flag is high for that cycle. The commands can search for a key, choose a slot for a new entry, write an entry, read an entry back, and empty the micro cache.

A separate lookup port translates a page number and identifier with one cycle of latency. The lookup first checks a small fully-associative micro cache of recently used joint entries. On a micro-cache miss it uses the joint array and copies the hit into the micro cache. One of the two write commands empties the micro cache and the other leaves it alone. Because of this, the micro cache can keep serving translations that the joint array has already evicted, until software empties it explicitly.

Top module: `tlb_top`

## Requirements
- R1: After reset the index register, both descriptor registers, the busy flag and the lookup hit/done outputs read zero, and no entry matches.
- R2: A write to the command register (select 3) sets busy for exactly the next cycle. The command executes in that cycle. Any register write offered while busy is high is ignored.
- R3: Probe (code 1) searches the set given by the low 7 bits of the key page number. On a single match it loads the linear index set*WAYS+way into index bits [IDX_W-1:0] and clears bits 31 and 30. On no match it loads 0x8000_0000.
- R4: When a probe matches more than one way, the index register reads 0xC000_0000.
- R5: An entry matches only if its present bit (descriptor-0 bit 8) is set, its page number (bits [27:9]) is equal to the key, and its identifier (bits [7:0]) is equal to the key.
- R6: Get-slot (code 2) loads the lowest-numbered invalid way of the key's set. If every way is valid, it loads the way named by that set's round-robin pointer. The pointer starts at 0 and advances by one each time it is used.
- R7: Write (code 3) stores both descriptors at the indexed entry and empties the micro cache. Writing zero descriptors erases the entry.
- R8: Write-keep (code 4) stores the entry and leaves the micro cache untouched, so a translation that was overwritten in the joint array is still served.
- R9: Micro flush (code 6) empties the micro cache and leaves the joint array unchanged.
- R10: Read (code 5) copies the indexed entry into descriptor 0 (page, present, identifier) and descriptor 1 (frame in bits [25:6], permissions in [5:0]).
- R11: A lookup result appears on the cycle after the request. A micro-cache hit takes priority over the joint array.
- R12: The micro cache holds 8 entries and is refilled on joint hits in round-robin order, so the ninth distinct fill replaces the first.
- R13: A lookup in the cycle a command executes sees the contents from before the command. If that command empties the micro cache, the fill from that lookup is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 2 | Register select: 0 index, 1 descriptor 0, 2 descriptor 1, 3 command |
| cfg_wdata_i | input | 32 | Register write data |
| index_o | output | 32 | Index register: bit 31 miss, bit 30 duplicate, low bits linear index |
| pd0_o | output | 28 | Descriptor 0: page [27:9], present [8], identifier [7:0] |
| pd1_o | output | 26 | Descriptor 1: frame [25:6], permissions [5:0] |
| busy_o | output | 1 | Command in execution |
| lk_req_i | input | 1 | Lookup request |
| lk_vpn_i | input | 19 | Lookup page number |
| lk_asid_i | input | 8 | Lookup identifier |
| lk_done_o | output | 1 | Lookup result valid |
| lk_hit_o | output | 1 | Lookup hit |
| lk_pfn_o | output | 20 | Frame number of the hit |
| lk_perm_o | output | 6 | Permissions of the hit |

## Verification
Command execution and a lookup can happen in the same cycle. This matters most when the command is a micro flush that competes with a refill. The bench places a lookup request in the exact cycle the flush executes. First it does this with a stale micro entry present, and the result must be the stale frame. Then it does this with an empty micro cache, and a later write-keep followed by another lookup must show the new joint frame, which proves that the refill was dropped. A scoreboard queue holds the expected lookup results, and the bench reads registers directly to judge every command.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    typedef enum logic [2:0] {
        CMD_NONE       = 3'd0,
        CMD_PROBE      = 3'd1,
        CMD_GETIDX     = 3'd2,
        CMD_WRITE      = 3'd3,
        CMD_WRITE_KEEP = 3'd4,
        CMD_READ       = 3'd5,
        CMD_UFLUSH     = 3'd6
    } tlb_cmd_e;

    localparam logic [1:0] SEL_INDEX = 2'd0;
    localparam logic [1:0] SEL_PD0   = 2'd1;
    localparam logic [1:0] SEL_PD1   = 2'd2;
    localparam logic [1:0] SEL_CMD   = 2'd3;

    localparam int REG_W = 32;
endpackage

// File: rtl/tlb_micro.sv
module tlb_micro #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 19,
    parameter int ASID_W  = 8,
    parameter int PFN_W   = 20,
    parameter int PERM_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              fill_i,
    input  logic [VPN_W-1:0]  fill_vpn_i,
    input  logic [ASID_W-1:0] fill_asid_i,
    input  logic [PFN_W-1:0]  fill_pfn_i,
    input  logic [PERM_W-1:0] fill_perm_i,
    input  logic [VPN_W-1:0]  lk_vpn_i,
    input  logic [ASID_W-1:0] lk_asid_i,
    output logic              hit_o,
    output logic [PFN_W-1:0]  pfn_o,
    output logic [PERM_W-1:0] perm_o
);
    localparam int PTR_W = $clog2(ENTRIES);

    typedef struct packed {
        logic [ENTRIES-1:0]             vld;
        logic [ENTRIES-1:0][VPN_W-1:0]  vpn;
        logic [ENTRIES-1:0][ASID_W-1:0] asid;
        logic [ENTRIES-1:0][PFN_W-1:0]  pfn;
        logic [ENTRIES-1:0][PERM_W-1:0] perm;
        logic [PTR_W-1:0]               ptr;
    } micro_t;

    micro_t m_d, m_q;

    // Flush wins over a fill offered in the same cycle.
    always_comb begin
        m_d = m_q;
        if (flush_i) begin
            m_d.vld = '0;
        end else if (fill_i) begin
            m_d.vld[m_q.ptr]  = 1'b1;
            m_d.vpn[m_q.ptr]  = fill_vpn_i;
            m_d.asid[m_q.ptr] = fill_asid_i;
            m_d.pfn[m_q.ptr]  = fill_pfn_i;
            m_d.perm[m_q.ptr] = fill_perm_i;
            m_d.ptr           = m_q.ptr + PTR_W'(1);
        end
    end

    always_comb begin
        hit_o  = 1'b0;
        pfn_o  = '0;
        perm_o = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (m_q.vld[i] && m_q.vpn[i] == lk_vpn_i && m_q.asid[i] == lk_asid_i) begin
                hit_o  = 1'b1;
                pfn_o  = m_q.pfn[i];
                perm_o = m_q.perm[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end
endmodule

// File: rtl/tlb_joint.sv
module tlb_joint #(
    parameter int SETS   = 128,
    parameter int WAYS   = 2,
    parameter int VPN_W  = 19,
    parameter int ASID_W = 8,
    parameter int PFN_W  = 20,
    parameter int PERM_W = 6
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 we_i,
    input  logic [$clog2(SETS)+$clog2(WAYS)-1:0] idx_i,
    input  logic                                 wvld_i,
    input  logic [VPN_W-1:0]                     wvpn_i,
    input  logic [ASID_W-1:0]                    wasid_i,
    input  logic [PFN_W-1:0]                     wpfn_i,
    input  logic [PERM_W-1:0]                    wperm_i,
    output logic                                 rvld_o,
    output logic [VPN_W-1:0]                     rvpn_o,
    output logic [ASID_W-1:0]                    rasid_o,
    output logic [PFN_W-1:0]                     rpfn_o,
    output logic [PERM_W-1:0]                    rperm_o,
    input  logic [VPN_W-1:0]                     key_vpn_i,
    input  logic [ASID_W-1:0]                    key_asid_i,
    output logic                                 phit_o,
    output logic                                 pdup_o,
    output logic [$clog2(SETS)+$clog2(WAYS)-1:0] pidx_o,
    input  logic                                 vtake_i,
    output logic [$clog2(SETS)+$clog2(WAYS)-1:0] vidx_o,
    input  logic [VPN_W-1:0]                     lk_vpn_i,
    input  logic [ASID_W-1:0]                    lk_asid_i,
    output logic                                 lhit_o,
    output logic [PFN_W-1:0]                     lpfn_o,
    output logic [PERM_W-1:0]                    lperm_o
);
    localparam int SET_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);
    localparam int IDX_W = SET_W + WAY_W;
    localparam int N     = SETS * WAYS;

    logic [N-1:0]      vld_q;
    logic [VPN_W-1:0]  vpn_q  [N];
    logic [ASID_W-1:0] asid_q [N];
    logic [PFN_W-1:0]  pfn_q  [N];
    logic [PERM_W-1:0] perm_q [N];
    logic [WAY_W-1:0]  rr_q   [SETS];

    logic [SET_W-1:0] kset, lset;
    logic [WAY_W:0]   pcount;
    logic [WAY_W-1:0] pway, vway;
    logic             vfree;

    assign kset = key_vpn_i[SET_W-1:0];
    assign lset = lk_vpn_i[SET_W-1:0];

    assign rvld_o  = vld_q[idx_i];
    assign rvpn_o  = vpn_q[idx_i];
    assign rasid_o = asid_q[idx_i];
    assign rpfn_o  = pfn_q[idx_i];
    assign rperm_o = perm_q[idx_i];

    // Probe: count matching ways of the addressed set.
    always_comb begin
        pcount = '0;
        pway   = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (vld_q[{kset, WAY_W'(w)}] && vpn_q[{kset, WAY_W'(w)}] == key_vpn_i &&
                asid_q[{kset, WAY_W'(w)}] == key_asid_i) begin
                pcount = pcount + (WAY_W+1)'(1);
                pway   = WAY_W'(w);
            end
        end
    end
    assign phit_o = (pcount == (WAY_W+1)'(1));
    assign pdup_o = (pcount > (WAY_W+1)'(1));
    assign pidx_o = {kset, pway};

    // Victim: lowest invalid way, else per-set round-robin pointer.
    always_comb begin
        vfree = 1'b0;
        vway  = rr_q[kset];
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!vld_q[{kset, WAY_W'(w)}]) begin
                vfree = 1'b1;
                vway  = WAY_W'(w);
            end
        end
    end
    assign vidx_o = {kset, vway};

    // Lookup port search.
    always_comb begin
        lhit_o  = 1'b0;
        lpfn_o  = '0;
        lperm_o = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (vld_q[{lset, WAY_W'(w)}] && vpn_q[{lset, WAY_W'(w)}] == lk_vpn_i &&
                asid_q[{lset, WAY_W'(w)}] == lk_asid_i) begin
                lhit_o  = 1'b1;
                lpfn_o  = pfn_q[{lset, WAY_W'(w)}];
                lperm_o = perm_q[{lset, WAY_W'(w)}];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
        end else begin
            if (we_i) vld_q[idx_i] <= wvld_i;
            if (vtake_i && !vfree) rr_q[kset] <= rr_q[kset] + WAY_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (we_i) begin
            vpn_q[idx_i]  <= wvpn_i;
            asid_q[idx_i] <= wasid_i;
            pfn_q[idx_i]  <= wpfn_i;
            perm_q[idx_i] <= wperm_i;
        end
    end
endmodule

// File: rtl/tlb_top.sv
module tlb_top
    import tlb_pkg::*;
#(
    parameter int SETS     = 128,
    parameter int WAYS     = 2,
    parameter int UENTRIES = 8,
    parameter int VPN_W    = 19,
    parameter int ASID_W   = 8,
    parameter int PFN_W    = 20,
    parameter int PERM_W   = 6,
    localparam int PD0_W   = VPN_W + 1 + ASID_W,
    localparam int PD1_W   = PFN_W + PERM_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we_i,
    input  logic [1:0]        cfg_sel_i,
    input  logic [31:0]       cfg_wdata_i,
    output logic [31:0]       index_o,
    output logic [PD0_W-1:0]  pd0_o,
    output logic [PD1_W-1:0]  pd1_o,
    output logic              busy_o,
    input  logic              lk_req_i,
    input  logic [VPN_W-1:0]  lk_vpn_i,
    input  logic [ASID_W-1:0] lk_asid_i,
    output logic              lk_done_o,
    output logic              lk_hit_o,
    output logic [PFN_W-1:0]  lk_pfn_o,
    output logic [PERM_W-1:0] lk_perm_o
);
    localparam int IDX_W = $clog2(SETS) + $clog2(WAYS);
    localparam int PAD_W = REG_W - 2 - IDX_W;

    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic              err;
        logic              dup;
        logic [PD0_W-1:0]  pd0;
        logic [PD1_W-1:0]  pd1;
        logic [2:0]        cmd;
        logic              busy;
        logic              lk_done;
        logic              lk_hit;
        logic [PFN_W-1:0]  lk_pfn;
        logic [PERM_W-1:0] lk_perm;
    } regs_t;

    regs_t r_d, r_q;

    logic              j_we, u_flush, v_take, u_fill;
    logic              key_vld;
    logic [VPN_W-1:0]  key_vpn;
    logic [ASID_W-1:0] key_asid;
    logic              j_rvld, j_phit, j_pdup, j_lhit, u_hit;
    logic [VPN_W-1:0]  j_rvpn;
    logic [ASID_W-1:0] j_rasid;
    logic [PFN_W-1:0]  j_rpfn, j_lpfn, u_pfn;
    logic [PERM_W-1:0] j_rperm, j_lperm, u_perm;
    logic [IDX_W-1:0]  j_pidx, j_vidx;
    logic              unused_wdata;

    assign unused_wdata = ^cfg_wdata_i[31:PD0_W];

    assign key_asid = r_q.pd0[ASID_W-1:0];
    assign key_vld  = r_q.pd0[ASID_W];
    assign key_vpn  = r_q.pd0[ASID_W+1 +: VPN_W];

    tlb_joint #(
        .SETS(SETS), .WAYS(WAYS), .VPN_W(VPN_W), .ASID_W(ASID_W),
        .PFN_W(PFN_W), .PERM_W(PERM_W)
    ) u_joint (
        .clk(clk), .rst_n(rst_n),
        .we_i(j_we), .idx_i(r_q.idx),
        .wvld_i(key_vld), .wvpn_i(key_vpn), .wasid_i(key_asid),
        .wpfn_i(r_q.pd1[PERM_W +: PFN_W]), .wperm_i(r_q.pd1[PERM_W-1:0]),
        .rvld_o(j_rvld), .rvpn_o(j_rvpn), .rasid_o(j_rasid),
        .rpfn_o(j_rpfn), .rperm_o(j_rperm),
        .key_vpn_i(key_vpn), .key_asid_i(key_asid),
        .phit_o(j_phit), .pdup_o(j_pdup), .pidx_o(j_pidx),
        .vtake_i(v_take), .vidx_o(j_vidx),
        .lk_vpn_i(lk_vpn_i), .lk_asid_i(lk_asid_i),
        .lhit_o(j_lhit), .lpfn_o(j_lpfn), .lperm_o(j_lperm)
    );

    tlb_micro #(
        .ENTRIES(UENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W),
        .PFN_W(PFN_W), .PERM_W(PERM_W)
    ) u_micro (
        .clk(clk), .rst_n(rst_n),
        .flush_i(u_flush), .fill_i(u_fill),
        .fill_vpn_i(lk_vpn_i), .fill_asid_i(lk_asid_i),
        .fill_pfn_i(j_lpfn), .fill_perm_i(j_lperm),
        .lk_vpn_i(lk_vpn_i), .lk_asid_i(lk_asid_i),
        .hit_o(u_hit), .pfn_o(u_pfn), .perm_o(u_perm)
    );

    always_comb begin
        r_d     = r_q;
        j_we    = 1'b0;
        u_flush = 1'b0;
        v_take  = 1'b0;

        if (r_q.busy) begin
            r_d.busy = 1'b0;
            case (r_q.cmd)
                CMD_PROBE: begin
                    r_d.idx = j_phit ? j_pidx : '0;
                    r_d.err = !j_phit;
                    r_d.dup = j_pdup;
                end
                CMD_GETIDX: begin
                    r_d.idx = j_vidx;
                    r_d.err = 1'b0;
                    r_d.dup = 1'b0;
                    v_take  = 1'b1;
                end
                CMD_WRITE: begin
                    j_we    = 1'b1;
                    u_flush = 1'b1;
                end
                CMD_WRITE_KEEP: j_we = 1'b1;
                CMD_READ: begin
                    r_d.pd0 = {j_rvpn, j_rvld, j_rasid};
                    r_d.pd1 = {j_rpfn, j_rperm};
                end
                CMD_UFLUSH: u_flush = 1'b1;
                default: ;
            endcase
        end else if (cfg_we_i) begin
            case (cfg_sel_i)
                SEL_INDEX: begin
                    r_d.idx = cfg_wdata_i[IDX_W-1:0];
                    r_d.err = 1'b0;
                    r_d.dup = 1'b0;
                end
                SEL_PD0: r_d.pd0 = cfg_wdata_i[PD0_W-1:0];
                SEL_PD1: r_d.pd1 = cfg_wdata_i[PD1_W-1:0];
                default: begin
                    r_d.cmd  = cfg_wdata_i[2:0];
                    r_d.busy = 1'b1;
                end
            endcase
        end

        r_d.lk_done = lk_req_i;
        r_d.lk_hit  = 1'b0;
        if (lk_req_i) begin
            if (u_hit) begin
                r_d.lk_hit  = 1'b1;
                r_d.lk_pfn  = u_pfn;
                r_d.lk_perm = u_perm;
            end else if (j_lhit) begin
                r_d.lk_hit  = 1'b1;
                r_d.lk_pfn  = j_lpfn;
                r_d.lk_perm = j_lperm;
            end
        end
    end

    assign u_fill = lk_req_i && !u_hit && j_lhit && !u_flush;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign index_o   = {r_q.err, r_q.dup, {PAD_W{1'b0}}, r_q.idx};
    assign pd0_o     = r_q.pd0;
    assign pd1_o     = r_q.pd1;
    assign busy_o    = r_q.busy;
    assign lk_done_o = r_q.lk_done;
    assign lk_hit_o  = r_q.lk_hit;
    assign lk_pfn_o  = r_q.lk_pfn;
    assign lk_perm_o = r_q.lk_perm;
endmodule

// File: rtl/tlb_chk.sv
module tlb_chk
    import tlb_pkg::*;
#(
    parameter int PD1_W = 26
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we_i,
    input logic [1:0]       cfg_sel_i,
    input logic [31:0]      index_o,
    input logic [PD1_W-1:0] pd1_o,
    input logic             busy_o,
    input logic             lk_done_o,
    input logic             lk_hit_o
);
    a_r2_busy_single: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> !busy_o);

    a_r2_cmd_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we_i && cfg_sel_i == SEL_CMD && !busy_o) |=> busy_o);

    a_r3_index_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !(cfg_we_i && cfg_sel_i == SEL_INDEX)) |=> $stable(index_o));

    a_r4_dup_flags_err: assert property (@(posedge clk) disable iff (!rst_n)
        index_o[30] |-> index_o[31]);

    a_r10_pd1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !(cfg_we_i && cfg_sel_i == SEL_PD1)) |=> $stable(pd1_o));

    a_r11_hit_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit_o |-> lk_done_o);
endmodule

bind tlb_top tlb_chk #(.PD1_W(PD1_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i),
    .index_o(index_o), .pd1_o(pd1_o), .busy_o(busy_o),
    .lk_done_o(lk_done_o), .lk_hit_o(lk_hit_o)
);

// File: tb/tlb_top_bench.sv
module tlb_top_bench;
    import tlb_pkg::*;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic        hit;
        logic [19:0] pfn;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we_i = 1'b0;
    logic [1:0]  cfg_sel_i = '0;
    logic [31:0] cfg_wdata_i = '0;
    logic [31:0] index_o;
    logic [27:0] pd0_o;
    logic [25:0] pd1_o;
    logic        busy_o;
    logic        lk_req_i = 1'b0;
    logic [18:0] lk_vpn_i = '0;
    logic [7:0]  lk_asid_i = '0;
    logic        lk_done_o, lk_hit_o;
    logic [19:0] lk_pfn_o;
    logic [5:0]  lk_perm_o;

    int   n_checks = 0;
    int   n_fails  = 0;
    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    tlb_top u_tlb_top (
        .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i),
        .cfg_wdata_i(cfg_wdata_i), .index_o(index_o), .pd0_o(pd0_o), .pd1_o(pd1_o),
        .busy_o(busy_o), .lk_req_i(lk_req_i), .lk_vpn_i(lk_vpn_i), .lk_asid_i(lk_asid_i),
        .lk_done_o(lk_done_o), .lk_hit_o(lk_hit_o), .lk_pfn_o(lk_pfn_o), .lk_perm_o(lk_perm_o)
    );

    function automatic logic [27:0] mk_pd0(input logic [18:0] vpn, input logic [7:0] asid, input logic v);
        return {vpn, v, asid};
    endfunction

    function automatic logic [25:0] mk_pd1(input logic [19:0] pfn, input logic [5:0] perm);
        return {pfn, perm};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_wdata_i = data;
        @(negedge clk);
        cfg_we_i = 1'b0;
    endtask

    task automatic do_cmd(input tlb_cmd_e code);
        reg_wr(SEL_CMD, 32'(code));
        @(negedge clk);
    endtask

    task automatic set_entry(input int idx, input logic [27:0] p0, input logic [25:0] p1);
        reg_wr(SEL_INDEX, 32'(idx));
        reg_wr(SEL_PD0, 32'(p0));
        reg_wr(SEL_PD1, 32'(p1));
    endtask

    task automatic probe(input logic [18:0] vpn, input logic [7:0] asid);
        reg_wr(SEL_PD0, 32'(mk_pd0(vpn, asid, 1'b1)));
        do_cmd(CMD_PROBE);
    endtask

    task automatic lookup(input logic [18:0] vpn, input logic [7:0] asid,
                          input logic hit, input logic [19:0] pfn, input string req);
        exp_t e;
        @(negedge clk);
        lk_req_i = 1'b1; lk_vpn_i = vpn; lk_asid_i = asid;
        e.hit = hit; e.pfn = pfn; e.req = req;
        sb_q.push_back(e);
        @(negedge clk);
        lk_req_i = 1'b0;
    endtask

    // Command write, then a lookup sampled in the command's execution cycle.
    task automatic cmd_with_lookup(input tlb_cmd_e code, input logic [18:0] vpn,
                                   input logic hit, input logic [19:0] pfn, input string req);
        exp_t e;
        @(negedge clk);
        cfg_we_i = 1'b1; cfg_sel_i = SEL_CMD; cfg_wdata_i = 32'(code);
        @(negedge clk);
        cfg_we_i = 1'b0;
        lk_req_i = 1'b1; lk_vpn_i = vpn; lk_asid_i = 8'd3;
        e.hit = hit; e.pfn = pfn; e.req = req;
        sb_q.push_back(e);
        @(negedge clk);
        lk_req_i = 1'b0;
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && lk_done_o) begin
            if (sb_q.size() == 0) begin
                n_checks++; n_fails++;
                $display("FAIL R11: unexpected lookup result actual hit %0b expected none", lk_hit_o);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                n_checks++;
                if (lk_hit_o !== e.hit || (e.hit && lk_pfn_o !== e.pfn)) begin
                    n_fails++;
                    $display("FAIL %s: lookup actual hit %0b pfn 0x%0h expected hit %0b pfn 0x%0h",
                             e.req, lk_hit_o, lk_pfn_o, e.hit, e.pfn);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 index", index_o, 32'h0);
        check("R1 pd0", 32'(pd0_o), 32'h0);
        check("R1 pd1", 32'(pd1_o), 32'h0);
        check("R1 busy", 32'(busy_o), 32'h0);
        check("R1 lk_hit", 32'(lk_hit_o), 32'h0);

        // R2 busy lasts one cycle; write during busy ignored. R3 miss on empty.
        reg_wr(SEL_PD0, 32'(mk_pd0(19'h105, 8'd3, 1'b1)));
        @(negedge clk);
        cfg_we_i = 1'b1; cfg_sel_i = SEL_CMD; cfg_wdata_i = 32'(CMD_PROBE);
        @(negedge clk);
        check("R2 busy set", 32'(busy_o), 32'h1);
        cfg_sel_i = SEL_PD1; cfg_wdata_i = 32'h123;
        @(negedge clk);
        cfg_we_i = 1'b0;
        check("R2 busy clear", 32'(busy_o), 32'h0);
        check("R2 pd1 write ignored", 32'(pd1_o), 32'h0);
        check("R3 probe miss", index_o, 32'h8000_0000);

        // R6 lowest invalid way; R3 probe hit index
        do_cmd(CMD_GETIDX);
        check("R6 getidx free way0", index_o, 32'd10);
        reg_wr(SEL_PD1, 32'(mk_pd1(20'h777, 6'h3F)));
        do_cmd(CMD_WRITE);
        probe(19'h105, 8'd3);
        check("R3 probe hit", index_o, 32'd10);

        // R5 identifier and page mismatch
        probe(19'h105, 8'd4);
        check("R5 asid mismatch", index_o, 32'h8000_0000);
        probe(19'h185, 8'd3);
        check("R5 vpn mismatch", index_o, 32'h8000_0000);

        // R6 free way1, then round robin
        do_cmd(CMD_GETIDX);
        check("R6 getidx free way1", index_o, 32'd11);
        reg_wr(SEL_PD1, 32'(mk_pd1(20'h888, 6'h15)));
        do_cmd(CMD_WRITE);
        do_cmd(CMD_GETIDX);
        check("R6 rr first", index_o, 32'd10);
        do_cmd(CMD_GETIDX);
        check("R6 rr second", index_o, 32'd11);
        do_cmd(CMD_GETIDX);
        check("R6 rr wrap", index_o, 32'd10);

        // R10 read back
        reg_wr(SEL_INDEX, 32'd11);
        do_cmd(CMD_READ);
        check("R10 read pd0", 32'(pd0_o), 32'(mk_pd0(19'h185, 8'd3, 1'b1)));
        check("R10 read pd1", 32'(pd1_o), 32'(mk_pd1(20'h888, 6'h15)));

        // R11 lookups
        lookup(19'h105, 8'd3, 1'b1, 20'h777, "R11 hit");
        lookup(19'h200, 8'd3, 1'b0, 20'h0, "R11 miss");
        lookup(19'h185, 8'd3, 1'b1, 20'h888, "R11 hit2");

        // R8 write-keep evicts joint entry, micro keeps serving it
        set_entry(10, mk_pd0(19'h305, 8'd3, 1'b1), mk_pd1(20'h999, 6'h0));
        do_cmd(CMD_WRITE_KEEP);
        lookup(19'h105, 8'd3, 1'b1, 20'h777, "R8 stale micro");
        probe(19'h105, 8'd3);
        check("R8 joint evicted", index_o, 32'h8000_0000);

        // R11 micro priority over joint
        set_entry(11, mk_pd0(19'h185, 8'd3, 1'b1), mk_pd1(20'hAAA, 6'h0));
        do_cmd(CMD_WRITE_KEEP);
        lookup(19'h185, 8'd3, 1'b1, 20'h888, "R11 micro priority");

        // R9 micro flush
        do_cmd(CMD_UFLUSH);
        probe(19'h305, 8'd3);
        check("R9 joint intact", index_o, 32'd10);
        lookup(19'h105, 8'd3, 1'b0, 20'h0, "R9 flushed");
        lookup(19'h185, 8'd3, 1'b1, 20'hAAA, "R9 refill");

        // R7 write clears micro; erase
        set_entry(11, mk_pd0(19'h185, 8'd3, 1'b1), mk_pd1(20'hBBB, 6'h0));
        do_cmd(CMD_WRITE_KEEP);
        set_entry(20, mk_pd0(19'h00A, 8'd3, 1'b1), mk_pd1(20'h123, 6'h0));
        do_cmd(CMD_WRITE);
        lookup(19'h185, 8'd3, 1'b1, 20'hBBB, "R7 micro cleared");
        set_entry(11, 28'h0, 26'h0);
        do_cmd(CMD_WRITE);
        probe(19'h185, 8'd3);
        check("R7 erased", index_o, 32'h8000_0000);

        // R4 duplicate
        set_entry(21, mk_pd0(19'h00A, 8'd3, 1'b1), mk_pd1(20'h124, 6'h0));
        do_cmd(CMD_WRITE);
        do_cmd(CMD_PROBE);
        check("R4 duplicate", index_o, 32'hC000_0000);

        // R12 micro round robin of 8
        for (int k = 0; k < 9; k++) begin
            set_entry((8'h40 + k) * 2, mk_pd0(19'(8'h40 + k), 8'd3, 1'b1), mk_pd1(20'(12'h500 + k), 6'h0));
            do_cmd(CMD_WRITE);
        end
        for (int k = 0; k < 9; k++)
            lookup(19'(8'h40 + k), 8'd3, 1'b1, 20'(12'h500 + k), "R12 fill");
        for (int k = 0; k < 2; k++) begin
            set_entry((8'h40 + k) * 2, mk_pd0(19'(8'h40 + k), 8'd3, 1'b1), mk_pd1(20'(12'h600 + k), 6'h0));
            do_cmd(CMD_WRITE_KEEP);
        end
        lookup(19'h41, 8'd3, 1'b1, 20'h501, "R12 second kept");
        lookup(19'h40, 8'd3, 1'b1, 20'h600, "R12 first replaced");

        // R13 lookup in a flush's execution cycle
        set_entry(8'h42 * 2, mk_pd0(19'h42, 8'd3, 1'b1), mk_pd1(20'h700, 6'h0));
        do_cmd(CMD_WRITE_KEEP);
        cmd_with_lookup(CMD_UFLUSH, 19'h42, 1'b1, 20'h502, "R13 pre-flush view");
        lookup(19'h42, 8'd3, 1'b1, 20'h700, "R13 flush took effect");
        do_cmd(CMD_UFLUSH);
        cmd_with_lookup(CMD_UFLUSH, 19'h42, 1'b1, 20'h700, "R13 joint hit");
        set_entry(8'h42 * 2, mk_pd0(19'h42, 8'd3, 1'b1), mk_pd1(20'h710, 6'h0));
        do_cmd(CMD_WRITE_KEEP);
        lookup(19'h42, 8'd3, 1'b1, 20'h710, "R13 fill dropped");

        repeat (3) @(negedge clk);
        check("R11 scoreboard drained", 32'(sb_q.size()), 32'h0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule